// File: doc/BRIEF.md
# Five-Stage Forwarding and Interlock Unit

This unit resolves operand hazards for an in-order pipeline whose stages run fetch, decode/register-read (D/R), ALU, data memory (DM) and register write (RW). Each cycle the decoder presents the class, source registers and destination of the instruction sitting in D/R. The unit keeps a small record of the two instructions ahead of it in ALU and DM, and from those records it decides two things. The first is whether the D/R instruction must wait, which freezes fetch and D/R and sends a bubble into ALU. The second is which latch each operand should come from once the instruction reaches ALU.

A mode input selects between full bypassing and a plain interlock. With the interlock, every consumer waits until its producer is in RW, because the register file writes early in a cycle and reads late in it. With bypassing, ALU results go straight to the next instruction's operands. A loaded value can also feed the data of an immediately following store in the DM stage. A load whose value feeds an ALU operand or an address costs one cycle.

Top module: `hz_fwd_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the ALU and DM stage records, so the first instruction after reset never stalls and all select outputs read 0.
- R2: An instruction with no dependence on the two instructions ahead of it is accepted in the same cycle (`stall` low), and its operand selects read 0 (register file) when it enters ALU.
- R3: With `byp_en` low, a consumer whose producer is d instructions ahead (d = 1 or 2) stalls for 3 - d cycles, and its operand selects and store-data select stay 0.
- R4: In every cycle that `stall` is high, the D/R instruction is held and the ALU stage receives a bubble: both ALU operand selects read 0 after that edge.
- R5: With `byp_en` high and an ALU-class producer, a consumer operand takes code 1 (ALU-output latch) when the producer is one ahead and code 2 (DM-output latch) when it is two ahead, with no stall.
- R6: With `byp_en` high, a store whose data register (operand b) is loaded by the instruction just ahead does not stall. Its operand-b select reads 0, and one cycle later `dm_sd_sel` reads 3 (RW latch).
- R7: With `byp_en` high, a load directly followed by a use of its register as an ALU operand, a load address or a store address stalls exactly one cycle, after which that operand select reads 2.
- R8: Select codes are 0 register file, 1 ALU-output latch, 2 DM-output latch and 3 RW latch. ALU operand selects never read 3, and `dm_sd_sel` reads only 0 or 3.
- R9: When both older instructions write the register a consumer reads, the one nearer to D/R decides both the stall and the select.
- R10: A destination of register 0, a low `dr_dst_en`, or an instruction of store or no-op class never causes a stall or a non-zero select.
- R11: Class encoding is 0 ALU (reads a and b), 1 load (reads a as address), 2 store (a is the address, b is the data), 3 no-op (reads nothing). Source fields that the class does not read have no effect.
- R12: `stall` is high only while `dr_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byp_en | input | 1 | 1 = forwarding on, 0 = interlock only |
| dr_valid | input | 1 | D/R stage holds an instruction |
| dr_cls | input | 2 | Class of the D/R instruction (R11 encoding) |
| dr_src_a | input | REG_W | Operand A register (ALU operand or address base) |
| dr_src_b | input | REG_W | Operand B register (ALU operand or store data) |
| dr_dst | input | REG_W | Destination register |
| dr_dst_en | input | 1 | Destination is written |
| stall | output | 1 | Hold fetch and D/R, bubble into ALU |
| alu_sel_a | output | 2 | Source of operand A for the instruction now in ALU |
| alu_sel_b | output | 2 | Source of operand B for the instruction now in ALU |
| dm_sd_sel | output | 2 | Source of store data for the instruction now in DM |

## Verification
The one-stall property for a load and its first use assumes that upstream logic keeps the D/R fields and `dr_valid` unchanged while `stall` is high. The check also applies only when `byp_en` has held its value across that cycle. The stimulus meets both conditions. It drives each instruction once, leaves it in place until `stall` drops, and changes `byp_en` only after no-ops have drained the pipeline. The sweep covers every producer class, every consumer class and operand, gaps of zero to three no-ops, and both modes. Each pairing is also repeated with a register-0 destination and with the write flag low.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int NSTG = 2;  // tracked stages ahead of D/R: ALU, DM

    typedef enum logic [1:0] {
        CLS_ALU   = 2'd0,
        CLS_LOAD  = 2'd1,
        CLS_STORE = 2'd2,
        CLS_NOP   = 2'd3
    } icls_e;

    typedef enum logic [1:0] {
        SEL_REGFILE = 2'd0,
        SEL_ALU_OUT = 2'd1,
        SEL_DM_OUT  = 2'd2,
        SEL_RW_LAT  = 2'd3
    } opsel_e;

    function automatic logic cls_writes(input icls_e c);
        return (c == CLS_ALU) || (c == CLS_LOAD);
    endfunction

endpackage

// File: rtl/hz_stage_match.sv
module hz_stage_match #(
    parameter int REG_W = 5
) (
    input  logic             vld,
    input  logic             wen,
    input  logic [REG_W-1:0] dst,
    input  logic [REG_W-1:0] src,
    input  logic             used,
    output logic             hit
);
    // register 0 is hard-wired and never produced
    assign hit = vld && wen && used && (dst != '0) && (dst == src);
endmodule

// File: rtl/hz_operand.sv
module hz_operand
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic                       byp_en,
    input  logic [REG_W-1:0]           src,
    input  logic                       used,
    input  logic                       is_sdata,
    input  logic [NSTG-1:0]            stg_vld,
    input  logic [NSTG-1:0]            stg_wen,
    input  logic [NSTG-1:0][REG_W-1:0] stg_dst,
    input  logic [NSTG-1:0]            stg_load,
    output logic                       need_stall,
    output logic [1:0]                 sel,
    output logic                       sd_fwd
);
    logic [NSTG-1:0] hit;
    opsel_e          sel_e;

    for (genvar s = 0; s < NSTG; s++) begin : g_stg
        hz_stage_match #(.REG_W(REG_W)) u_match (
            .vld (stg_vld[s]),
            .wen (stg_wen[s]),
            .dst (stg_dst[s]),
            .src (src),
            .used(used),
            .hit (hit[s])
        );
    end

    // oldest first, so the youngest hit (index 0 = ALU stage) wins
    always_comb begin
        need_stall = 1'b0;
        sel_e      = SEL_REGFILE;
        sd_fwd     = 1'b0;
        if (byp_en) begin
            for (int s = NSTG - 1; s >= 0; s--) begin
                if (hit[s]) begin
                    need_stall = 1'b0;
                    sd_fwd     = 1'b0;
                    sel_e      = opsel_e'(2'(s + 1));
                    if (s == 0 && stg_load[0]) begin
                        sel_e = SEL_REGFILE;
                        if (is_sdata) sd_fwd     = 1'b1;
                        else          need_stall = 1'b1;
                    end
                end
            end
        end else begin
            need_stall = |hit;
        end
    end

    assign sel = sel_e;
endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             byp_en,
    input  logic             dr_valid,
    input  logic [1:0]       dr_cls,
    input  logic [REG_W-1:0] dr_src_a,
    input  logic [REG_W-1:0] dr_src_b,
    input  logic [REG_W-1:0] dr_dst,
    input  logic             dr_dst_en,
    output logic             stall,
    output logic [1:0]       alu_sel_a,
    output logic [1:0]       alu_sel_b,
    output logic [1:0]       dm_sd_sel
);
    localparam int NOPS = 2;

    typedef struct packed {
        logic             vld;
        logic             wen;
        logic [REG_W-1:0] dst;
        logic             load;
    } stg_t;

    typedef struct packed {
        stg_t       alu;
        stg_t       dm;
        logic [1:0] sel_a;
        logic [1:0] sel_b;
        logic       sd_pend;
        logic [1:0] sd_sel;
    } st_t;

    st_t st_d, st_q;
    icls_e cls;

    logic [NOPS-1:0][REG_W-1:0] op_src;
    logic [NOPS-1:0]            op_use, op_sdat, op_stall, op_sdf;
    logic [NOPS-1:0][1:0]       op_sel;
    logic [NSTG-1:0]            stg_vld, stg_wen, stg_load;
    logic [NSTG-1:0][REG_W-1:0] stg_dst;

    assign cls        = icls_e'(dr_cls);
    assign op_src[0]  = dr_src_a;
    assign op_src[1]  = dr_src_b;
    assign op_use[0]  = dr_valid && (cls != CLS_NOP);
    assign op_use[1]  = dr_valid && (cls == CLS_ALU || cls == CLS_STORE);
    assign op_sdat[0] = 1'b0;
    assign op_sdat[1] = (cls == CLS_STORE);

    assign stg_vld  = {st_q.dm.vld,  st_q.alu.vld};
    assign stg_wen  = {st_q.dm.wen,  st_q.alu.wen};
    assign stg_dst  = {st_q.dm.dst,  st_q.alu.dst};
    assign stg_load = {st_q.dm.load, st_q.alu.load};

    for (genvar k = 0; k < NOPS; k++) begin : g_op
        hz_operand #(.REG_W(REG_W)) u_op (
            .byp_en    (byp_en),
            .src       (op_src[k]),
            .used      (op_use[k]),
            .is_sdata  (op_sdat[k]),
            .stg_vld   (stg_vld),
            .stg_wen   (stg_wen),
            .stg_dst   (stg_dst),
            .stg_load  (stg_load),
            .need_stall(op_stall[k]),
            .sel       (op_sel[k]),
            .sd_fwd    (op_sdf[k])
        );
    end

    assign stall = |op_stall;

    always_comb begin
        st_d        = st_q;
        st_d.dm     = st_q.alu;
        st_d.sd_sel = st_q.sd_pend ? SEL_RW_LAT : SEL_REGFILE;
        if (stall || !dr_valid) begin
            st_d.alu     = '0;
            st_d.sel_a   = SEL_REGFILE;
            st_d.sel_b   = SEL_REGFILE;
            st_d.sd_pend = 1'b0;
        end else begin
            st_d.alu.vld  = 1'b1;
            st_d.alu.wen  = dr_dst_en && cls_writes(cls);
            st_d.alu.dst  = dr_dst;
            st_d.alu.load = (cls == CLS_LOAD);
            st_d.sel_a    = op_sel[0];
            st_d.sel_b    = op_sel[1];
            st_d.sd_pend  = op_sdf[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign alu_sel_a = st_q.sel_a;
    assign alu_sel_b = st_q.sel_b;
    assign dm_sd_sel = st_q.sd_sel;

    // R1: reset leaves every select on the register-file path
    p_rst_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (alu_sel_a == 2'd0 && alu_sel_b == 2'd0 && dm_sd_sel == 2'd0));

    // R3: interlock mode never forwards into ALU
    p_nobyp_regfile_r3: assert property (@(posedge clk) disable iff (rst)
        !byp_en |=> (alu_sel_a == 2'd0 && alu_sel_b == 2'd0));

    // R4: a stall cycle sends a bubble into ALU
    p_stall_bubble_r4: assert property (@(posedge clk) disable iff (rst)
        stall |=> (alu_sel_a == 2'd0 && alu_sel_b == 2'd0));

    // R6: store-data forwarding only appears with bypassing on
    p_sd_needs_byp_r6: assert property (@(posedge clk) disable iff (rst)
        !byp_en |=> ##1 (dm_sd_sel == 2'd0));

    // R7: with bypassing held on and D/R frozen, a stall lasts one cycle
    p_loaduse_once_r7: assert property (@(posedge clk) disable iff (rst)
        (byp_en && $past(byp_en) && !$past(rst) && $past(stall) &&
         $stable(dr_valid) && $stable(dr_cls) &&
         $stable(dr_src_a) && $stable(dr_src_b)) |-> !stall);

    // R8: code space per output
    p_sel_codes_r8: assert property (@(posedge clk) disable iff (rst)
        (alu_sel_a != 2'd3) && (alu_sel_b != 2'd3) &&
        (dm_sd_sel == 2'd0 || dm_sd_sel == 2'd3));

    // R12: no stall without an instruction in D/R
    p_stall_valid_r12: assert property (@(posedge clk) disable iff (rst)
        stall |-> dr_valid);

endmodule

// File: tb/sim_hz_fwd_unit.sv
`timescale 1ns/1ps
module sim_hz_fwd_unit;
    localparam int RW = 5;
    localparam logic [1:0] C_ALU = 2'd0, C_LD = 2'd1, C_ST = 2'd2, C_NOP = 2'd3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          byp_en = 1'b0;
    logic          dr_valid = 1'b0;
    logic [1:0]    dr_cls = C_NOP;
    logic [RW-1:0] dr_src_a = '0, dr_src_b = '0, dr_dst = '0;
    logic          dr_dst_en = 1'b0;
    logic          stall;
    logic [1:0]    alu_sel_a, alu_sel_b, dm_sd_sel;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    hz_fwd_unit #(.REG_W(RW)) u0 (
        .clk(clk), .rst(rst), .byp_en(byp_en), .dr_valid(dr_valid),
        .dr_cls(dr_cls), .dr_src_a(dr_src_a), .dr_src_b(dr_src_b),
        .dr_dst(dr_dst), .dr_dst_en(dr_dst_en), .stall(stall),
        .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b), .dm_sd_sel(dm_sd_sel)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // call at a negedge; returns at the negedge after acceptance
    task automatic issue(input logic [1:0] c, input logic [RW-1:0] a, input logic [RW-1:0] b,
                         input logic [RW-1:0] d, input logic den, output int nst,
                         output int sa, output int sb, output int sd);
        dr_valid = 1'b1; dr_cls = c; dr_src_a = a; dr_src_b = b;
        dr_dst = d; dr_dst_en = den;
        nst = 0;
        #1;
        while (stall && nst < 8) begin
            nst++;
            @(negedge clk);
            chk("R4 bubble sel_a", int'(alu_sel_a), 0);
            chk("R4 bubble sel_b", int'(alu_sel_b), 0);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        sa = int'(alu_sel_a); sb = int'(alu_sel_b); sd = int'(dm_sd_sel);
    endtask

    task automatic nop(output int nst, output int sd);
        int sa, sb;
        issue(C_NOP, 5'd7, 5'd7, 5'd7, 1'b1, nst, sa, sb, sd);
    endtask

    task automatic drain();
        int n, sd;
        for (int i = 0; i < 3; i++) nop(n, sd);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int nst, sa, sb, sd, gst;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 stall after reset", int'(stall), 0);
        chk("R1 sel_a after reset", int'(alu_sel_a), 0);
        chk("R1 sd after reset", int'(dm_sd_sel), 0);
        @(negedge clk);

        // R1: reset wipes an in-flight producer
        byp_en = 1'b1;
        issue(C_LD, 5'd1, 5'd2, 5'd9, 1'b1, nst, sa, sb, sd);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        issue(C_ALU, 5'd9, 5'd9, 5'd12, 1'b1, nst, sa, sb, sd);
        chk("R1 no stall after reset", nst, 0);
        chk("R1 sel_a after reset", sa, 0);
        drain();

        // R12: no valid -> no stall even with a hazard pattern present
        issue(C_LD, 5'd1, 5'd2, 5'd7, 1'b1, nst, sa, sb, sd);
        dr_valid = 1'b0; dr_cls = C_ALU; dr_src_a = 5'd7; dr_src_b = 5'd7;
        #1;
        chk("R12 stall without valid", int'(stall), 0);
        @(negedge clk);
        drain();

        // main sweep
        for (int b = 0; b < 2; b++)
        for (int pi = 0; pi < 2; pi++)
        for (int cc = 0; cc < 3; cc++)
        for (int op = 0; op < 2; op++)
        for (int gap = 0; gap < 4; gap++)
        for (int v = 0; v < 3; v++) begin
            automatic logic [1:0] pc = (pi == 0) ? C_ALU : C_LD;
            automatic logic [RW-1:0] pd = (v == 1) ? 5'd0 : 5'd7;
            automatic logic [RW-1:0] ca = (op == 0) ? pd : 5'd3;
            automatic logic [RW-1:0] cb = (op == 1) ? pd : 5'd3;
            automatic int d = gap + 1;
            automatic bit used = (op == 0) || (cc != 1);
            automatic bit hit = (v == 0) && used;
            automatic int est = 0, esel = 0, esd = 0;
            automatic string tag;
            byp_en = b[0];
            if (!hit)             tag = (v != 0) ? "R10" : "R11";
            else if (b == 0)      tag = "R3";
            else if (d >= 3)      tag = "R2";
            else if (pc == C_LD && d == 1) tag = (cc == 2 && op == 1) ? "R6" : "R7";
            else                  tag = "R5";
            if (hit) begin
                if (b == 0) est = (d < 3) ? 3 - d : 0;
                else if (pc == C_LD && d == 1) begin
                    if (cc == 2 && op == 1) esd = 3;
                    else begin est = 1; esel = 2; end
                end else esel = (d == 1) ? 1 : ((d == 2) ? 2 : 0);
            end
            issue(pc, 5'd1, 5'd2, pd, (v != 2), nst, sa, sb, sd);
            gst = 0;
            for (int g = 0; g < gap; g++) begin
                nop(nst, sd);
                gst += nst;
            end
            if (gap > 0) chk("R11 no-op sources ignored", gst, 0);
            issue(cc[1:0], ca, cb, 5'd12, 1'b1, nst, sa, sb, sd);
            chk({tag, " stall cycles"}, nst, est);
            chk({tag, " used select"}, (op == 0) ? sa : sb, esel);
            chk("R8 other select", (op == 0) ? sb : sa, 0);
            nop(nst, sd);
            chk({tag, " store-data select"}, sd, esd);
            drain();
        end

        // R9: youngest producer wins
        byp_en = 1'b1;
        issue(C_ALU, 5'd1, 5'd2, 5'd7, 1'b1, nst, sa, sb, sd);
        issue(C_ALU, 5'd1, 5'd2, 5'd7, 1'b1, nst, sa, sb, sd);
        issue(C_ALU, 5'd7, 5'd3, 5'd12, 1'b1, nst, sa, sb, sd);
        chk("R9 two ALU producers sel", sa, 1);
        drain();
        issue(C_LD, 5'd1, 5'd2, 5'd7, 1'b1, nst, sa, sb, sd);
        issue(C_ALU, 5'd1, 5'd2, 5'd7, 1'b1, nst, sa, sb, sd);
        issue(C_ALU, 5'd3, 5'd7, 5'd12, 1'b1, nst, sa, sb, sd);
        chk("R9 older load ignored stall", nst, 0);
        chk("R9 older load ignored sel", sb, 1);
        drain();
        issue(C_ALU, 5'd1, 5'd2, 5'd7, 1'b1, nst, sa, sb, sd);
        issue(C_LD, 5'd1, 5'd2, 5'd7, 1'b1, nst, sa, sb, sd);
        issue(C_ALU, 5'd7, 5'd3, 5'd12, 1'b1, nst, sa, sb, sd);
        chk("R9 young load stall", nst, 1);
        chk("R9 young load sel", sa, 2);
        drain();

        // R10: store destination field is not a write
        issue(C_ST, 5'd1, 5'd2, 5'd7, 1'b1, nst, sa, sb, sd);
        issue(C_ALU, 5'd7, 5'd7, 5'd12, 1'b1, nst, sa, sb, sd);
        chk("R10 store dest stall", nst, 0);
        chk("R10 store dest sel", sa, 0);
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule